// File: doc/BRIEF.md
# Serial Multicycle Instruction Sequencer

This block is the control engine of a small register/memory processor that runs one instruction at a time. Each instruction walks through a fixed chain of phases, and each phase borrows exactly one functional unit: instruction fetch (cache, then main memory if the cache misses), decode, register read, data fetch (same cache-then-memory path), ALU execute, and register update. The block holds the program counter, the instruction register, and a storage register that catches every word coming back from the cache or memory. The cache, main memory, ALU and register file sit outside the block and are reached through their ports.

The cache, memory and ALU ports are valid/ready requests. The sequencer raises `valid` and holds the request fields steady until the partner raises `ready`. The response travels on the same beat. The partner may hold `ready` low for any number of cycles, and that stretches the phase. The sequencer never withdraws a request. Register-file reads and writes are plain one-cycle strobes, and the read data must be valid in the strobe cycle.

Instruction word (16 bits by default, LSB first): offset[3:0], index register[5:4], base register[7:6], destination/first-operand register[9:8], index-enable bit 10, base-enable bit 11, memory-operand bit 12, ALU opcode[15:13].

Top module: `rm_sequencer`

## Requirements
- R1: In any cycle at most one of cache request, memory request, register read, ALU request and register write is active, and the next instruction's fetch request appears only after the current instruction's register write.
- R2: The instruction-fetch cache request carries the address equal to the PC value of the current instruction, including the first fetch after reset (address 0).
- R3: A cache, memory or ALU request stays valid with unchanged address/operands until the cycle its `ready` is high. Response data and the hit flag are taken only in that cycle.
- R4: A cache response with the hit flag low is followed by a main-memory request to the same address. The word used is the one memory returns, not the cache data.
- R5: The fetched word lands in the storage register first and is copied into the instruction register in a later cycle. After the fetch, `ir_out` equals the memory word at the PC.
- R6: With bit 12 low, the instruction is register-only: it makes no data-fetch request, and its second ALU operand is the register named by bits [7:6]. With no waits and a cache hit, it takes exactly 7 cycles.
- R7: The data-fetch address is the zero-extended offset, plus the base register if bit 11 is set, plus the index register if bit 10 is set, truncated to the data width.
- R8: The ALU request carries opcode bits [15:13], operand A equal to the register named by bits [9:8], and operand B equal to the storage register (the fetched data word, or the register operand for register-only instructions).
- R9: The update cycle writes the ALU result into the register named by bits [9:8], and the PC increases by exactly one. The PC changes at no other time.
- R10: After each instruction, `last_cycles` equals its total cycle count: 5 + (1 + cache waits) + (1 + ALU waits), plus (1 + memory waits) for an instruction-fetch miss, plus 1 + (1 + cache waits) for a memory operand, plus (1 + memory waits) for a data miss. The count saturates at the counter width.
- R11: Synchronous active-high reset clears the PC and `last_cycles` to zero, drops every request and strobe, and restarts at instruction fetch, even in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_req_valid | output | 1 | Cache access requested |
| cache_req_ready | input | 1 | Cache accepts and responds this cycle |
| cache_req_addr | output | DATA_W | Cache access address |
| cache_rsp_hit | input | 1 | Response is a hit (valid with ready) |
| cache_rsp_data | input | DATA_W | Hit data (valid with ready) |
| mem_req_valid | output | 1 | Main-memory access requested |
| mem_req_ready | input | 1 | Memory accepts and responds this cycle |
| mem_req_addr | output | DATA_W | Memory access address |
| mem_rsp_data | input | DATA_W | Memory data (valid with ready) |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_addr_a | output | REG_AW | Read port A: first operand register |
| rf_rd_addr_b | output | REG_AW | Read port B: base / second operand register |
| rf_rd_addr_x | output | REG_AW | Read port X: index register |
| rf_rd_data_a | input | DATA_W | Port A data |
| rf_rd_data_b | input | DATA_W | Port B data |
| rf_rd_data_x | input | DATA_W | Port X data |
| alu_req_valid | output | 1 | ALU operation requested |
| alu_req_ready | input | 1 | ALU result valid this cycle |
| alu_op | output | OP_W | ALU opcode |
| alu_opnd_a | output | DATA_W | ALU operand A (register) |
| alu_opnd_b | output | DATA_W | ALU operand B (storage register) |
| alu_result | input | DATA_W | ALU result |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_addr | output | REG_AW | Write register |
| rf_wr_data | output | DATA_W | Write data |
| pc_out | output | DATA_W | Program counter |
| ir_out | output | DATA_W | Instruction register |
| instr_done | output | 1 | Update cycle of the current instruction |
| last_cycles | output | CNT_W | Cycle count of the last finished instruction |

## Verification
The assertions rely on the partners following the handshake. Responses are looked at only in a `ready` cycle, the register-file read data is valid in the strobe cycle, and `ready` may come at any time while `valid` is high. The bench's responders raise `ready` only while the matching `valid` is high, after a programmable number of wait cycles. They return a wrong word on a cache miss, so a design that used miss data would be caught. The wait counts change only between instructions, so each instruction's expected cycle count is fixed when it starts. The program covers hits and misses on both fetch paths and every addressing combination.

// File: rtl/rmseq_pkg.sv
package rmseq_pkg;

  typedef enum logic [3:0] {
    ST_IADDR,
    ST_ICACHE,
    ST_IMEM,
    ST_IXFER,
    ST_DEC,
    ST_RDREG,
    ST_DADDR,
    ST_DCACHE,
    ST_DMEM,
    ST_EXEC,
    ST_UPD
  } seq_state_e;

  // one-cycle control strobes from the sequencer to the datapath
  typedef struct packed {
    logic ld_iar;
    logic cache_v;
    logic mem_v;
    logic sel_data;
    logic ld_sr_fetch;
    logic ld_ir;
    logic ld_dec;
    logic rf_rd;
    logic ld_sr_reg;
    logic ld_dar;
    logic alu_v;
    logic ld_res;
    logic upd;
  } seq_ctl_t;

endpackage

// File: rtl/rmseq_agu.sv
module rmseq_agu #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] idx,
  input  logic              use_base,
  input  logic              use_idx,
  output logic [DATA_W-1:0] addr
);
  localparam int PAD_W = DATA_W - OFF_W;

  logic [DATA_W-1:0] off_ext, base_term, idx_term;

  assign off_ext   = {{PAD_W{1'b0}}, off};
  assign base_term = use_base ? base : '0;
  assign idx_term  = use_idx  ? idx  : '0;
  assign addr      = off_ext + base_term + idx_term;
endmodule

// File: rtl/rmseq_cyccnt.sv
module rmseq_cyccnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  output logic [CNT_W-1:0] last
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_q, run_inc;

  assign run_inc = (run_q == CNT_MAX) ? CNT_MAX : run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      last  <= '0;
    end else if (done) begin
      last  <= run_inc;
      run_q <= '0;
    end else begin
      run_q <= run_inc;
    end
  end

  // R10: the shortest path (register-only, no waits) is seven cycles
  p_cyc_floor_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> last >= CNT_W'(7));
endmodule

// File: rtl/rmseq_ctrl.sv
module rmseq_ctrl
  import rmseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cache_ready,
  input  logic     cache_hit,
  input  logic     mem_ready,
  input  logic     alu_ready,
  input  logic     dec_mem,
  output seq_ctl_t ctl
);
  seq_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IADDR;
    else     st_q <= st_d;
  end

  always_comb begin
    ctl  = '0;
    st_d = st_q;
    unique case (st_q)
      ST_IADDR: begin
        ctl.ld_iar = 1'b1;
        st_d       = ST_ICACHE;
      end
      ST_ICACHE: begin
        ctl.cache_v = 1'b1;
        if (cache_ready) begin
          if (cache_hit) begin
            ctl.ld_sr_fetch = 1'b1;
            st_d            = ST_IXFER;
          end else begin
            st_d = ST_IMEM;
          end
        end
      end
      ST_IMEM: begin
        ctl.mem_v = 1'b1;
        if (mem_ready) begin
          ctl.ld_sr_fetch = 1'b1;
          st_d            = ST_IXFER;
        end
      end
      ST_IXFER: begin
        ctl.ld_ir = 1'b1;
        st_d      = ST_DEC;
      end
      ST_DEC: begin
        ctl.ld_dec = 1'b1;
        st_d       = ST_RDREG;
      end
      ST_RDREG: begin
        ctl.rf_rd = 1'b1;
        if (dec_mem) begin
          st_d = ST_DADDR;
        end else begin
          ctl.ld_sr_reg = 1'b1;
          st_d          = ST_EXEC;
        end
      end
      ST_DADDR: begin
        ctl.ld_dar = 1'b1;
        st_d       = ST_DCACHE;
      end
      ST_DCACHE: begin
        ctl.cache_v  = 1'b1;
        ctl.sel_data = 1'b1;
        if (cache_ready) begin
          if (cache_hit) begin
            ctl.ld_sr_fetch = 1'b1;
            st_d            = ST_EXEC;
          end else begin
            st_d = ST_DMEM;
          end
        end
      end
      ST_DMEM: begin
        ctl.mem_v    = 1'b1;
        ctl.sel_data = 1'b1;
        if (mem_ready) begin
          ctl.ld_sr_fetch = 1'b1;
          st_d            = ST_EXEC;
        end
      end
      ST_EXEC: begin
        ctl.alu_v = 1'b1;
        if (alu_ready) begin
          ctl.ld_res = 1'b1;
          st_d       = ST_UPD;
        end
      end
      ST_UPD: begin
        ctl.upd = 1'b1;
        st_d    = ST_IADDR;
      end
      default: st_d = ST_IADDR;
    endcase
  end

  // R1: one functional unit per cycle
  p_one_unit_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.cache_v, ctl.mem_v, ctl.rf_rd, ctl.alu_v, ctl.upd}));

  // R1: a register write is followed by a fresh fetch, never a leftover unit
  p_serial_restart_r1: assert property (@(posedge clk) disable iff (rst)
    ctl.upd |=> ctl.ld_iar);

  // R3: an unanswered cache request is held
  p_cache_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.cache_v && !cache_ready |=> ctl.cache_v);

  // R4: a miss falls back to main memory
  p_miss_to_mem_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.cache_v && cache_ready && !cache_hit |=> ctl.mem_v);

  // R6: register-only goes from register read straight to the ALU
  p_regonly_skip_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.rf_rd && !dec_mem |=> ctl.alu_v);
endmodule

// File: rtl/rm_sequencer.sv
module rm_sequencer
  import rmseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 2,
  parameter int OP_W   = 3,
  parameter int OFF_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cache_req_valid,
  input  logic              cache_req_ready,
  output logic [DATA_W-1:0] cache_req_addr,
  input  logic              cache_rsp_hit,
  input  logic [DATA_W-1:0] cache_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [DATA_W-1:0] mem_req_addr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rf_rd_en,
  output logic [REG_AW-1:0] rf_rd_addr_a,
  output logic [REG_AW-1:0] rf_rd_addr_b,
  output logic [REG_AW-1:0] rf_rd_addr_x,
  input  logic [DATA_W-1:0] rf_rd_data_a,
  input  logic [DATA_W-1:0] rf_rd_data_b,
  input  logic [DATA_W-1:0] rf_rd_data_x,
  output logic              alu_req_valid,
  input  logic              alu_req_ready,
  output logic [OP_W-1:0]   alu_op,
  output logic [DATA_W-1:0] alu_opnd_a,
  output logic [DATA_W-1:0] alu_opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] ir_out,
  output logic              instr_done,
  output logic [CNT_W-1:0]  last_cycles
);
  // instruction field positions, packed from bit 0 upward
  localparam int RX_LO  = OFF_W;
  localparam int RB_LO  = RX_LO + REG_AW;
  localparam int RD_LO  = RB_LO + REG_AW;
  localparam int IE_BIT = RD_LO + REG_AW;
  localparam int BE_BIT = IE_BIT + 1;
  localparam int M_BIT  = BE_BIT + 1;
  localparam int OP_LO  = M_BIT + 1;

  seq_ctl_t          ctl;
  logic [DATA_W-1:0] pc_q, ir_q, sr_q, iar_q, dar_q;
  logic [DATA_W-1:0] opa_q, base_q, idx_q, res_q, agu_addr;
  logic              dec_mem_q, dec_be_q, dec_ie_q;
  logic [DATA_W-1:0] acc_addr;

  rmseq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cache_ready (cache_req_ready),
    .cache_hit   (cache_rsp_hit),
    .mem_ready   (mem_req_ready),
    .alu_ready   (alu_req_ready),
    .dec_mem     (dec_mem_q),
    .ctl         (ctl)
  );

  rmseq_agu #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_agu (
    .off      (ir_q[OFF_W-1:0]),
    .base     (base_q),
    .idx      (idx_q),
    .use_base (dec_be_q),
    .use_idx  (dec_ie_q),
    .addr     (agu_addr)
  );

  rmseq_cyccnt #(.CNT_W(CNT_W)) u_cyccnt (
    .clk  (clk),
    .rst  (rst),
    .done (ctl.upd),
    .last (last_cycles)
  );

  // program counter: moves only in the update cycle
  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (ctl.upd) pc_q <= pc_q + 1'b1;
  end

  // address registers, storage register, instruction register
  always_ff @(posedge clk) begin
    if (rst) begin
      iar_q <= '0;
      dar_q <= '0;
      sr_q  <= '0;
      ir_q  <= '0;
    end else begin
      if (ctl.ld_iar) iar_q <= pc_q;
      if (ctl.ld_dar) dar_q <= agu_addr;
      if (ctl.ld_sr_fetch)
        sr_q <= ctl.mem_v ? mem_rsp_data : cache_rsp_data;
      else if (ctl.ld_sr_reg)
        sr_q <= rf_rd_data_b;
      if (ctl.ld_ir) ir_q <= sr_q;
    end
  end

  // decoded type/mode flags and captured register operands
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_mem_q <= 1'b0;
      dec_be_q  <= 1'b0;
      dec_ie_q  <= 1'b0;
      opa_q     <= '0;
      base_q    <= '0;
      idx_q     <= '0;
      res_q     <= '0;
    end else begin
      if (ctl.ld_dec) begin
        dec_mem_q <= ir_q[M_BIT];
        dec_be_q  <= ir_q[BE_BIT];
        dec_ie_q  <= ir_q[IE_BIT];
      end
      if (ctl.rf_rd) begin
        opa_q  <= rf_rd_data_a;
        base_q <= rf_rd_data_b;
        idx_q  <= rf_rd_data_x;
      end
      if (ctl.ld_res) res_q <= alu_result;
    end
  end

  assign acc_addr        = ctl.sel_data ? dar_q : iar_q;
  assign cache_req_valid = ctl.cache_v;
  assign cache_req_addr  = acc_addr;
  assign mem_req_valid   = ctl.mem_v;
  assign mem_req_addr    = acc_addr;
  assign rf_rd_en        = ctl.rf_rd;
  assign rf_rd_addr_a    = ir_q[RD_LO +: REG_AW];
  assign rf_rd_addr_b    = ir_q[RB_LO +: REG_AW];
  assign rf_rd_addr_x    = ir_q[RX_LO +: REG_AW];
  assign alu_req_valid   = ctl.alu_v;
  assign alu_op          = ir_q[OP_LO +: OP_W];
  assign alu_opnd_a      = opa_q;
  assign alu_opnd_b      = sr_q;
  assign rf_we           = ctl.upd;
  assign rf_wr_addr      = ir_q[RD_LO +: REG_AW];
  assign rf_wr_data      = res_q;
  assign pc_out          = pc_q;
  assign ir_out          = ir_q;
  assign instr_done      = ctl.upd;

  // R2: the instruction fetch targets the current PC
  p_ifetch_pc_r2: assert property (@(posedge clk) disable iff (rst)
    cache_req_valid && !ctl.sel_data |-> cache_req_addr == pc_q);

  // R3: address held steady while the cache stalls
  p_cache_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    cache_req_valid && !cache_req_ready |=> cache_req_valid && $stable(cache_req_addr));

  // R3: memory request held with the same address
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8: ALU operands do not move while the ALU stalls
  p_alu_hold_r8: assert property (@(posedge clk) disable iff (rst)
    alu_req_valid && !alu_req_ready |=> alu_req_valid && $stable(alu_opnd_a) && $stable(alu_opnd_b));

  // R9: each write advances the PC by one
  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> pc_q == $past(pc_q) + 1'b1);

  // R9: without a write the PC holds
  p_pc_still_r9: assert property (@(posedge clk) disable iff (rst)
    !rf_we |=> $stable(pc_q));
endmodule

// File: tb/rm_sequencer_bench.sv
module rm_sequencer_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        cache_req_valid, cache_req_ready = 1'b0;
  logic [15:0] cache_req_addr;
  logic        cache_rsp_hit = 1'b0;
  logic [15:0] cache_rsp_data = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic [15:0] mem_rsp_data = '0;
  logic        rf_rd_en;
  logic [1:0]  rf_rd_addr_a, rf_rd_addr_b, rf_rd_addr_x;
  logic [15:0] rf_rd_data_a, rf_rd_data_b, rf_rd_data_x;
  logic        alu_req_valid, alu_req_ready = 1'b0;
  logic [2:0]  alu_op;
  logic [15:0] alu_opnd_a, alu_opnd_b;
  logic [15:0] alu_result = '0;
  logic        rf_we;
  logic [1:0]  rf_wr_addr;
  logic [15:0] rf_wr_data, pc_out, ir_out;
  logic        instr_done;
  logic [7:0]  last_cycles;

  rm_sequencer u_rm_sequencer (.*);

  logic [15:0] mem [0:255];
  logic [15:0] rf  [0:3];
  logic [15:0] mrf [0:3];

  assign rf_rd_data_a = rf[rf_rd_addr_a];
  assign rf_rd_data_b = rf[rf_rd_addr_b];
  assign rf_rd_data_x = rf[rf_rd_addr_x];

  int checks = 0, fails = 0, cyc = 0, ndone = 0;
  int cw = 0, mw = 0, aw = 0, c_cnt = 0, m_cnt = 0, a_cnt = 0;
  int n_cache = 0, n_mem = 0, exp_cyc = 0;
  bit cyc_pending = 0, wd = 0;
  logic [15:0] model_pc = '0, last_caddr = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_hit(input logic [15:0] a);
    return !(a == 16'h3 || a == 16'h6 || a == 16'h85 || a == 16'h8A);
  endfunction

  function automatic logic [15:0] alu_f(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return b;
      3'd6: return {a[14:0], 1'b0} ^ b;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] enc(input int op, input int m, input int be, input int ie,
                                      input int rd, input int rb, input int rx, input int off);
    return {op[2:0], m[0], be[0], ie[0], rd[1:0], rb[1:0], rx[1:0], off[3:0]};
  endfunction

  // R7: expected data address from the model's registers
  function automatic logic [15:0] daddr(input logic [15:0] ins);
    logic [15:0] s;
    s = {12'd0, ins[3:0]};
    if (ins[11]) s = s + mrf[ins[7:6]];
    if (ins[10]) s = s + mrf[ins[5:4]];
    return s;
  endfunction

  function automatic logic [15:0] opnd_b(input logic [15:0] ins);
    logic [15:0] da;
    da = daddr(ins);
    return ins[12] ? mem[da[7:0]] : mrf[ins[7:6]];
  endfunction

  always @(negedge clk) begin
    logic [15:0] ins, a, exp_w;
    bit mi, md;
    cyc++;
    ins = mem[model_pc[7:0]];
    cache_req_ready = 1'b0;
    mem_req_ready   = 1'b0;
    alu_req_ready   = 1'b0;
    if (rst) begin
      // R11: reset state at the ports
      chk("R11 pc", pc_out, 0);
      chk("R11 cycles", last_cycles, 0);
      chk("R11 idle", {cache_req_valid, mem_req_valid, alu_req_valid, rf_rd_en, rf_we}, 0);
      model_pc = '0; n_cache = 0; n_mem = 0; c_cnt = 0; m_cnt = 0; a_cnt = 0;
      cyc_pending = 0;
    end else begin
      if (cyc_pending) begin
        chk("R10 cycle count", last_cycles, exp_cyc);
        cyc_pending = 0;
      end
      chk("R1 one unit", $countones({cache_req_valid, mem_req_valid, alu_req_valid, rf_rd_en, rf_we}) <= 1, 1);
      chk("R9 pc", pc_out, model_pc);
      if (cache_req_valid) begin
        if (c_cnt == cw) begin
          a = (n_cache == 0) ? model_pc : daddr(ins);
          chk(n_cache == 0 ? "R2 fetch addr" : "R7 data addr", cache_req_addr, a);
          cache_req_ready = 1'b1;
          cache_rsp_hit   = is_hit(cache_req_addr);
          cache_rsp_data  = cache_rsp_hit ? mem[cache_req_addr[7:0]] : ~mem[cache_req_addr[7:0]];
          last_caddr = cache_req_addr;
          n_cache++; c_cnt = 0;
        end else c_cnt++;
      end
      if (mem_req_valid) begin
        if (m_cnt == mw) begin
          chk("R4 miss addr", mem_req_addr, last_caddr);
          mem_req_ready = 1'b1;
          mem_rsp_data  = mem[mem_req_addr[7:0]];
          n_mem++; m_cnt = 0;
        end else m_cnt++;
      end
      if (alu_req_valid) begin
        if (a_cnt == aw) begin
          chk("R8 op", alu_op, ins[15:13]);
          chk("R8 opnd a", alu_opnd_a, mrf[ins[9:8]]);
          chk("R8 opnd b", alu_opnd_b, opnd_b(ins));
          alu_req_ready = 1'b1;
          alu_result    = alu_f(alu_op, alu_opnd_a, alu_opnd_b);
          a_cnt = 0;
        end else a_cnt++;
      end
      if (instr_done) begin
        mi = !is_hit(model_pc);
        md = ins[12] && !is_hit(daddr(ins));
        exp_w = alu_f(ins[15:13], mrf[ins[9:8]], opnd_b(ins));
        chk("R5 ir", ir_out, ins);
        chk("R9 we", rf_we, 1);
        chk("R9 waddr", rf_wr_addr, ins[9:8]);
        chk("R9 wdata", rf_wr_data, exp_w);
        chk("R6 cache accesses", n_cache, ins[12] ? 2 : 1);
        chk("R4 memory accesses", n_mem, int'(mi) + int'(md));
        exp_cyc = 5 + (1 + cw) + (1 + aw) + (mi ? 1 + mw : 0)
                + (ins[12] ? 2 + cw : 0) + (md ? 1 + mw : 0);
        cyc_pending = 1;
        mrf[ins[9:8]] = exp_w;
        rf[rf_wr_addr] = rf_wr_data;
        model_pc = model_pc + 16'd1;
        n_cache = 0; n_mem = 0;
        ndone++;
        if (ndone == 6) begin cw = 2; mw = 3; aw = 1; end
      end
    end
    if (cyc > 5000 && !wd) begin
      wd = 1; fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", ndone, 14);
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ (16'(i) * 16'h0107);
    mem[0]  = enc(0,0,0,0, 0,3,0,0);   // reg-only add
    mem[1]  = enc(5,1,1,0, 3,1,0,2);   // load, base
    mem[2]  = enc(4,1,1,1, 0,1,2,1);   // xor, base+index
    mem[3]  = enc(1,0,0,0, 2,0,0,0);   // reg-only sub, fetch miss
    mem[4]  = enc(2,1,1,0, 3,1,0,5);   // and, data miss
    mem[5]  = enc(3,1,0,0, 0,0,0,9);   // or, offset only
    mem[6]  = enc(5,1,1,0, 2,1,0,10);  // fetch miss and data miss
    mem[7]  = enc(0,0,0,0, 3,1,0,0);
    mem[8]  = enc(7,1,1,0, 0,1,0,15);
    mem[9]  = enc(1,1,1,0, 0,1,0,0);
    mem[10] = enc(4,0,0,0, 1,1,0,0);   // r1 cleared
    mem[11] = enc(5,1,1,0, 2,1,0,3);   // data address 3, miss
    rf[0] = 16'd5; rf[1] = 16'h0080; rf[2] = 16'd3; rf[3] = 16'hFFF8;
    for (int i = 0; i < 4; i++) mrf[i] = rf[i];
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    while (ndone < 12 && !wd) @(negedge clk);
    // R11: reset in the middle of an instruction
    repeat (4) @(negedge clk);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    while (ndone < 14 && !wd) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule